// File: doc/BRIEF.md
# MDIO Management Command Engine

This block lets a host manage an Ethernet PHY through two 16-bit registers: a command register and a data register. To write a PHY register, software first loads the value into the data register. It then writes a command word that carries the direction, the PHY address and the register number. Writing the command word starts the transaction. To read a PHY register, software writes only the command word. When the transaction ends, the value returned by the PHY is in the data register.

The engine builds a clause-22 management frame and shifts it out on MDC/MDIO. MDC comes from the system clock through a divider set by a parameter. The engine releases its MDIO driver when the PHY has to drive the line. Software polls a sticky finish bit in the command register, both before issuing a command and after it. Nothing pulls MDIO low when no PHY answers, so a read of an absent address returns all ones.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the finish bit (command register bit 15) reads 1. The data register reads 0, MDC is low and the MDIO driver is disabled.
- R2: A command-register write while the finish bit is 1 starts a transaction. The finish bit reads 0 from the next cycle. It returns to 1 after exactly 64 MDC rising edges.
- R3: The frame is sent MSB first in this order: 32 ones, start code 01, opcode, 5-bit PHY address, 5-bit register number, 2 turnaround bits, 16 data bits. Command bit 13 set selects opcode 01 (write) and clear selects 10 (read). The PHY address comes from command bits 12:8 and the register number from bits 4:0.
- R4: Command bits 7:5 are ignored. Reading the command register back gives bit 15 as the finish flag, bit 13 as the direction, bits 12:8 as the address and bits 4:0 as the register; all other bits read 0.
- R5: In a write frame the engine drives turnaround 10. It then sends the 16-bit value held in the data register when the command was written.
- R6: In a read frame the engine releases MDIO for the final 18 bit times (turnaround and data) and never drives it while the PHY does. The 16 bits sampled are in the data register once the finish bit reads 1.
- R7: A read from an address where no PHY answers leaves the data register at 0xFFFF.
- R8: While a transaction is in progress, writes to either register are ignored. The frame, the command readback and the data register are unaffected.
- R9: MDC high and low phases each last DIV_HALF system clocks. MDIO output changes only on MDC falling edges, and the engine samples MDIO on MDC rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the command register, 1 the data register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
A bench PHY model decodes every frame and checks each field. A design that swaps the opcode codes or shifts the address field would therefore mis-address the PHY. Such a design fails the decoded-field and readback checks. Writes are injected while a transaction is running; a design that accepts them would corrupt the frame or the data register. The bench flags any cycle in which both sides drive MDIO, so an early or late release during a read is caught. Reads of an absent address must return 0xFFFF, and a capture off by one bit or one phase would return a shifted value.

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int CNT_W = $clog2(DIV_HALF + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);
  localparam logic [5:0] TA_BIT = 6'd46;
  localparam logic [5:0] RD_BIT = 6'd48;

  logic             busy;
  logic             cmd_wr;
  logic [CNT_W-1:0] dcnt;
  logic [5:0]       bitcnt;
  logic [63:0]      sr;
  logic [15:0]      rx_q;
  logic [15:0]      data_q;
  logic [10:0]      cmd_q;

  wire launch = reg_wr && !reg_sel && !busy;
  wire tick   = busy && (dcnt == CNT_LAST);
  wire rise   = tick && !mdc;
  wire fall   = tick && mdc;
  wire last   = fall && (bitcnt == 6'd63);
  wire unused_ok = &{1'b0, reg_wdata[15:14], reg_wdata[7:5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cmd_wr <= 1'b0;
      dcnt   <= '0;
      mdc    <= 1'b0;
      bitcnt <= '0;
      sr     <= '0;
      rx_q   <= '0;
      cmd_q  <= '0;
    end else if (launch) begin
      busy   <= 1'b1;
      cmd_wr <= reg_wdata[13];
      dcnt   <= '0;
      mdc    <= 1'b0;
      bitcnt <= '0;
      cmd_q  <= {reg_wdata[13], reg_wdata[12:8], reg_wdata[4:0]};
      sr     <= {32'hFFFF_FFFF, 2'b01, reg_wdata[13] ? 2'b01 : 2'b10,
                 reg_wdata[12:8], reg_wdata[4:0], 2'b10, data_q};
    end else if (busy) begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      if (tick) mdc <= ~mdc;
      if (rise && bitcnt >= RD_BIT) rx_q <= {rx_q[14:0], mdio_i};
      if (fall) begin
        sr     <= {sr[62:0], 1'b0};
        bitcnt <= bitcnt + 1'b1;
      end
      if (last) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        data_q <= '0;
    else if (last && !cmd_wr)          data_q <= rx_q;
    else if (reg_wr && reg_sel && !busy) data_q <= reg_wdata;
  end

  assign mdio_o    = sr[63];
  assign mdio_oe   = busy && (cmd_wr || bitcnt < TA_BIT);
  assign reg_rdata = reg_sel ? data_q
                             : {~busy, 1'b0, cmd_q[10], cmd_q[9:5], 3'b000, cmd_q[4:0]};
endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic        reg_sel,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        cmd_wr,
  input logic [15:0] data_q
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && !reg_sel) |=> busy);

  a_r6_release_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $fell(mdio_oe)) |-> !cmd_wr);

  a_r8_data_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(busy, 2)) |-> $stable(data_q) || !cmd_wr);

  a_r9_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  a_r9_mdc_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mdc != $past(mdc))) |=> (mdc == $past(mdc)) || !busy);
endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .busy(busy), .cmd_wr(cmd_wr), .data_q(data_q)
);

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;
  localparam int DIV_HALF = 2;
  localparam logic [4:0] PHY_ADR = 5'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mdc, mdio_o, mdio_oe;
  logic phy_oe = 1'b0;
  logic phy_o = 1'b1;
  logic line;

  assign line = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

  always #2.5 clk = ~clk;

  mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(line)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] phy_regs [32];
  logic [15:0] exp_regs [32];
  logic [63:0] fr;
  logic [15:0] rdval;
  int phy_idx = 0;
  int rises = 0;
  int conflicts = 0;
  int per_bad = 0;
  int hcnt = 0;
  bit seen = 0;
  logic mdc_prev = 1'b0;

  function automatic logic [15:0] init_val(int i);
    return 16'hA500 ^ (16'(i) * 16'h0111);
  endfunction

  function automatic logic [15:0] exp_read(logic [4:0] phy, logic [4:0] rg);
    return (phy == PHY_ADR) ? exp_regs[rg] : 16'hFFFF;
  endfunction

  always @(posedge mdc) begin
    if (phy_idx < 64) fr[63 - phy_idx] = line;
    phy_idx++;
    rises++;
    if (phy_idx == 64 && fr[29:28] == 2'b01 && fr[27:23] == PHY_ADR)
      phy_regs[fr[22:18]] = fr[15:0];
  end

  always @(negedge mdc) begin
    if (phy_idx >= 47 && phy_idx <= 63 && fr[29:28] == 2'b10 && fr[27:23] == PHY_ADR) begin
      if (phy_idx == 47) rdval = phy_regs[fr[22:18]];
      phy_oe = 1'b1;
      phy_o  = (phy_idx == 47) ? 1'b0 : rdval[63 - phy_idx];
    end else begin
      phy_oe = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mdio_oe && phy_oe) conflicts++;
      if (mdc != mdc_prev) begin
        if (seen && hcnt != DIV_HALF) per_bad++;
        seen = 1;
        hcnt = 1;
      end else begin
        hcnt++;
      end
      mdc_prev = mdc;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    reg_sel = 1'b0;
    while (!reg_rdata[15] && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk(reg_rdata[15], "R2 finish timeout", 64'(reg_rdata), 64'h8000);
  endtask

  task automatic do_cmd(input bit wr, input logic [4:0] phy, input logic [4:0] rg,
                        input logic [2:0] junk, input logic [15:0] wd, input bit poke);
    logic [15:0] cw;
    logic [15:0] exp_rb;
    logic [15:0] exp_d;
    if (wr) wr_reg(1'b1, wd);
    cw = {2'b11, wr, phy, junk, rg};
    exp_rb = {1'b0, 1'b0, wr, phy, 3'b000, rg};
    phy_idx = 0; rises = 0; seen = 0;
    wr_reg(1'b0, cw);
    chk(reg_rdata == exp_rb, "R2 R4 busy readback", 64'(reg_rdata), 64'(exp_rb));
    if (poke) begin
      repeat (20) @(negedge clk);
      wr_reg(1'b1, ~wd);
      wr_reg(1'b0, {2'b00, ~wr, ~phy, 3'b000, ~rg});
      chk(reg_rdata == exp_rb, "R8 cmd ignored while busy", 64'(reg_rdata), 64'(exp_rb));
    end
    wait_done();
    chk(rises == 64, "R2 rising edge count", 64'(rises), 64'd64);
    chk(fr[63:30] == {32'hFFFF_FFFF, 2'b01}, "R3 preamble/start", fr[63:30], {32'hFFFF_FFFF, 2'b01});
    chk(fr[29:28] == (wr ? 2'b01 : 2'b10), "R3 opcode", 64'(fr[29:28]), wr ? 64'd1 : 64'd2);
    chk(fr[27:18] == {phy, rg}, "R3 R4 address fields", 64'(fr[27:18]), 64'({phy, rg}));
    if (wr) begin
      chk(fr[17:0] == {2'b10, wd}, "R5 turnaround+data", 64'(fr[17:0]), 64'({2'b10, wd}));
      if (phy == PHY_ADR) exp_regs[rg] = wd;
      exp_d = wd;
    end else begin
      exp_d = exp_read(phy, rg);
      chk(fr[15:0] == exp_d, phy == PHY_ADR ? "R6 line data" : "R7 line idle ones",
          64'(fr[15:0]), 64'(exp_d));
    end
    reg_sel = 1'b1;
    @(negedge clk);
    chk(reg_rdata == exp_d, wr ? "R8 data reg kept" : (phy == PHY_ADR ? "R6 read data" : "R7 absent 0xFFFF"),
        64'(reg_rdata), 64'(exp_d));
    reg_sel = 1'b0;
    @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 idle after frame", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5EED;
    void'($urandom(seed));
    for (int i = 0; i < 32; i++) begin
      phy_regs[i] = init_val(i);
      exp_regs[i] = init_val(i);
    end
    repeat (3) @(negedge clk);
    chk(reg_rdata[15] == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset state",
        64'({reg_rdata[15], mdc, mdio_oe}), 64'h4);
    rst_n = 1'b1;
    reg_sel = 1'b1;
    @(negedge clk);
    chk(reg_rdata == 16'h0000, "R1 data reg reset", 64'(reg_rdata), 64'h0);
    reg_sel = 1'b0;

    do_cmd(1'b0, PHY_ADR, 5'd2, 3'b000, 16'h0, 1'b0);
    do_cmd(1'b1, PHY_ADR, 5'd31, 3'b111, 16'h8001, 1'b0);
    do_cmd(1'b0, PHY_ADR, 5'd31, 3'b101, 16'h0, 1'b0);
    do_cmd(1'b0, 5'd17, 5'd1, 3'b000, 16'h0, 1'b0);
    do_cmd(1'b1, PHY_ADR, 5'd0, 3'b010, 16'h0000, 1'b1);
    do_cmd(1'b0, PHY_ADR, 5'd0, 3'b000, 16'h0, 1'b1);
    do_cmd(1'b1, 5'd9, 5'd4, 3'b000, 16'h1234, 1'b0);
    do_cmd(1'b0, PHY_ADR, 5'd4, 3'b000, 16'h0, 1'b0);

    for (int t = 0; t < 30; t++) begin
      logic [4:0] pa;
      pa = ($urandom % 4 == 0) ? 5'($urandom) : PHY_ADR;
      do_cmd(1'($urandom), pa, 5'($urandom), 3'($urandom), 16'($urandom), 1'($urandom % 5 == 0));
    end

    chk(conflicts == 0, "R6 no bus contention", 64'(conflicts), 64'd0);
    chk(per_bad == 0, "R9 MDC half period", 64'(per_bad), 64'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule